// File: doc/BRIEF.md
# Receiver Equalization Request Sequencer

This block sits on the link-layer side of one lane. It asks the physical layer to run receiver equalization and then handles the completion handshake that comes back. A command carries two things: a choice between a full equalization run and a bypass run, and the 4-bit transmitter preset of the link partner. Once a command is accepted, the sequencer drives a 2-bit request code toward the PHY and holds the preset steady. It then waits for the PHY's one-cycle done pulse.

Each done pulse is classified by the adaptation flag that arrives in the same cycle. If the flag is high, the attempt succeeded. The returned 18-bit word and its select bit are latched, and a one-cycle result pulse is raised. If the flag is low, the attempt failed. The sequencer drops to idle for one cycle and then issues the same request again. When the configured number of attempts has run out, a sticky failure flag is set and the block stays idle until the next command.

The command input is a valid/ready pair. `cmd_ready` is high only while no request is outstanding. A command offered while a request is outstanding is held off by back-pressure and has no effect. The result output is a plain one-cycle pulse and cannot apply back-pressure, so the consumer must take it in the cycle it appears.

Top module: `rx_eq_sequencer`

## Requirements
- R1: `phy_eq_ctrl` uses code 00 for idle, 10 for an equalization run (`cmd_bypass`=0) and 11 for a bypass run (`cmd_bypass`=1), and code 01 is never driven.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only when no request is outstanding, and a command offered while a request is outstanding changes neither the request code nor the preset.
- R3: `phy_lp_preset` carries the `cmd_preset` value of the accepted command, unchanged, for every attempt of that command.
- R4: In the cycle after `phy_eq_done` is sampled high during a request, `phy_eq_ctrl` is 00.
- R5: When `phy_eq_done` and `phy_adapt_done` are both high during a request, `res_valid` is high for exactly the next cycle. In that cycle `res_preset_sel` and `res_coef` carry the values sampled with the done pulse.
- R6: If the sampled `phy_preset_sel` is 1, `res_coef[17:4]` is zero and `res_coef[3:0]` holds `phy_new_coef[3:0]`. If it is 0, `res_coef` holds all 18 bits of `phy_new_coef`.
- R7: A done pulse with `phy_adapt_done` low, while attempts remain, is followed by exactly one idle cycle with `cmd_ready` low. The same request code and preset are then issued again.
- R8: After MAX_ATTEMPTS (default 4) consecutive failed attempts, `eq_failed` rises in the cycle after the last done pulse. `phy_eq_ctrl` is then 00, `cmd_ready` is 1, and no further request is issued.
- R9: `eq_failed` stays high until the next accepted command, and it is low in the cycle after that acceptance.
- R10: A done pulse while `phy_eq_ctrl` is 00 is ignored: `res_valid` stays low, `res_coef` is unchanged, and no request starts.
- R11: After reset, `phy_eq_ctrl` is 00, `cmd_ready` is 1, and `res_valid`, `eq_failed` and `res_coef` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle; command can be taken |
| cmd_bypass | input | 1 | 1 selects a bypass run, 0 a full run |
| cmd_preset | input | 4 | Link-partner transmitter preset for the command |
| phy_eq_ctrl | output | 2 | Request code to the PHY |
| phy_lp_preset | output | 4 | Preset presented with the request |
| phy_eq_done | input | 1 | One-cycle completion pulse from the PHY |
| phy_adapt_done | input | 1 | Adaptation success flag, valid with done |
| phy_preset_sel | input | 1 | 1: returned word is a preset, 0: coefficients |
| phy_new_coef | input | 18 | Returned coefficient set or preset |
| res_valid | output | 1 | One-cycle result pulse on success |
| res_preset_sel | output | 1 | Latched select bit |
| res_coef | output | 18 | Latched word, zero-extended when a preset |
| eq_failed | output | 1 | Sticky flag: retry limit exhausted |

## Verification
The hardest state to reach from the ports is exhaustion of the retry limit. Getting there takes a chain of failed attempts, and every link in the chain needs its own done pulse, timed after the idle gap of the previous failure. A PHY model in the bench answers each request after a chosen latency. Each vector in the table gives the number of failures to return before a success, so one vector returns failures until the limit is reached. Two directed tests then check that the failure flag stays set across idle cycles and across a stray done pulse, and that it clears on the next command.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

  typedef enum logic [1:0] {
    EQ_CTRL_IDLE   = 2'b00,
    EQ_CTRL_RSVD   = 2'b01,
    EQ_CTRL_RUN    = 2'b10,
    EQ_CTRL_BYPASS = 2'b11
  } eq_ctrl_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_REQ  = 2'b01,
    ST_GAP  = 2'b10
  } seq_state_e;

  typedef struct packed {
    logic success;
    logic retry;
    logic exhaust;
  } done_class_t;

endpackage

// File: rtl/eqs_retry_ctr.sv
module eqs_retry_ctr #(
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_first,
  input  logic bump,
  output logic at_limit
);
  localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_ATTEMPTS);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);

  logic [CNT_W-1:0] attempt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attempt_q <= '0;
    end else if (load_first) begin
      attempt_q <= FIRST;
    end else if (bump && !at_limit) begin
      attempt_q <= attempt_q + FIRST;
    end
  end

  assign at_limit = (attempt_q >= LIMIT);

endmodule

// File: rtl/eqs_seq_fsm.sv
module eqs_seq_fsm
  import eqs_pkg::*;
#(
  parameter int PRESET_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic                cmd_bypass,
  input  logic [PRESET_W-1:0] cmd_preset,
  input  logic                phy_eq_done,
  input  logic                phy_adapt_done,
  input  logic                at_limit,
  output logic                cmd_ready,
  output logic                cmd_fire,
  output eq_ctrl_e            ctrl_code,
  output logic [PRESET_W-1:0] lp_preset,
  output done_class_t         outcome,
  output logic                failed
);
  seq_state_e          state_q, state_d;
  logic                bypass_q;
  logic [PRESET_W-1:0] preset_q;
  logic                fail_q;
  logic                in_req;

  assign cmd_ready = (state_q == ST_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign in_req    = (state_q == ST_REQ);

  // A done pulse is classified only while a request is outstanding.
  always_comb begin
    outcome = '0;
    if (in_req && phy_eq_done) begin
      if (phy_adapt_done) begin
        outcome.success = 1'b1;
      end else if (at_limit) begin
        outcome.exhaust = 1'b1;
      end else begin
        outcome.retry = 1'b1;
      end
    end
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (cmd_fire) state_d = ST_REQ;
      ST_REQ: begin
        if (outcome.retry) begin
          state_d = ST_GAP;
        end else if (outcome.success || outcome.exhaust) begin
          state_d = ST_IDLE;
        end
      end
      ST_GAP:  state_d = ST_REQ;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bypass_q <= 1'b0;
      preset_q <= '0;
      fail_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (cmd_fire) begin
        bypass_q <= cmd_bypass;
        preset_q <= cmd_preset;
        fail_q   <= 1'b0;
      end else if (outcome.exhaust) begin
        fail_q <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrl_code = EQ_CTRL_IDLE;
    if (in_req) begin
      ctrl_code = bypass_q ? EQ_CTRL_BYPASS : EQ_CTRL_RUN;
    end
  end

  assign lp_preset = preset_q;
  assign failed    = fail_q;

endmodule

// File: rtl/eqs_result_latch.sv
module eqs_result_latch #(
  parameter int COEF_W   = 18,
  parameter int PRESET_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              raw_sel,
  input  logic [COEF_W-1:0] raw_word,
  output logic              out_valid,
  output logic              out_sel,
  output logic [COEF_W-1:0] out_word
);
  logic [COEF_W-1:0] shaped;

  // Preset words keep only their low bits; the rest are forced to zero.
  for (genvar b = 0; b < COEF_W; b++) begin : g_shape
    if (b < PRESET_W) begin : g_low
      assign shaped[b] = raw_word[b];
    end else begin : g_high
      assign shaped[b] = raw_word[b] & ~raw_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sel   <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= capture;
      if (capture) begin
        out_sel  <= raw_sel;
        out_word <= shaped;
      end
    end
  end

endmodule

// File: rtl/rx_eq_sequencer.sv
module rx_eq_sequencer
  import eqs_pkg::*;
#(
  parameter int COEF_W       = 18,
  parameter int PRESET_W     = 4,
  parameter int MAX_ATTEMPTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_bypass,
  input  logic [PRESET_W-1:0] cmd_preset,
  output logic [1:0]          phy_eq_ctrl,
  output logic [PRESET_W-1:0] phy_lp_preset,
  input  logic                phy_eq_done,
  input  logic                phy_adapt_done,
  input  logic                phy_preset_sel,
  input  logic [COEF_W-1:0]   phy_new_coef,
  output logic                res_valid,
  output logic                res_preset_sel,
  output logic [COEF_W-1:0]   res_coef,
  output logic                eq_failed
);
  logic        fire;
  logic        at_limit;
  eq_ctrl_e    code;
  done_class_t outcome;

  eqs_seq_fsm #(.PRESET_W(PRESET_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_bypass     (cmd_bypass),
    .cmd_preset     (cmd_preset),
    .phy_eq_done    (phy_eq_done),
    .phy_adapt_done (phy_adapt_done),
    .at_limit       (at_limit),
    .cmd_ready      (cmd_ready),
    .cmd_fire       (fire),
    .ctrl_code      (code),
    .lp_preset      (phy_lp_preset),
    .outcome        (outcome),
    .failed         (eq_failed)
  );

  eqs_retry_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_first (fire),
    .bump       (outcome.retry),
    .at_limit   (at_limit)
  );

  eqs_result_latch #(.COEF_W(COEF_W), .PRESET_W(PRESET_W)) u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (outcome.success),
    .raw_sel   (phy_preset_sel),
    .raw_word  (phy_new_coef),
    .out_valid (res_valid),
    .out_sel   (res_preset_sel),
    .out_word  (res_coef)
  );

  assign phy_eq_ctrl = code;

endmodule

// File: rtl/rx_eq_sequencer_chk.sv
module rx_eq_sequencer_chk #(
  parameter int COEF_W       = 18,
  parameter int PRESET_W     = 4,
  parameter int MAX_ATTEMPTS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                cmd_bypass,
  input logic [PRESET_W-1:0] cmd_preset,
  input logic [1:0]          phy_eq_ctrl,
  input logic [PRESET_W-1:0] phy_lp_preset,
  input logic                phy_eq_done,
  input logic                phy_adapt_done,
  input logic                phy_preset_sel,
  input logic [COEF_W-1:0]   phy_new_coef,
  input logic                res_valid,
  input logic                res_preset_sel,
  input logic [COEF_W-1:0]   res_coef,
  input logic                eq_failed
);
  p_ctrl_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    phy_eq_ctrl != 2'b01);

  p_ready_only_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> phy_eq_ctrl == 2'b00);

  p_preset_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_eq_ctrl != 2'b00 && $past(phy_eq_ctrl) != 2'b00) |-> $stable(phy_lp_preset));

  p_idle_after_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_eq_ctrl != 2'b00 && phy_eq_done) |=> phy_eq_ctrl == 2'b00);

  p_valid_from_success_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(phy_eq_done && phy_adapt_done && phy_eq_ctrl != 2'b00));

  p_valid_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_preset_zero_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_preset_sel) |-> res_coef[COEF_W-1:PRESET_W] == '0);

  p_gap_then_reissue_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_eq_ctrl == 2'b00 && !cmd_ready) |=> phy_eq_ctrl != 2'b00);

  p_exhaust_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eq_failed) |-> (phy_eq_ctrl == 2'b00 && cmd_ready &&
                          $past(phy_eq_done && !phy_adapt_done)));

  p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eq_failed && !(cmd_valid && cmd_ready)) |=> eq_failed);

  p_fail_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !eq_failed);

  p_idle_done_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_eq_ctrl == 2'b00 && phy_eq_done) |=> (!res_valid && $stable(res_coef)));

endmodule

bind rx_eq_sequencer rx_eq_sequencer_chk #(
  .COEF_W(COEF_W), .PRESET_W(PRESET_W), .MAX_ATTEMPTS(MAX_ATTEMPTS)
) u_chk (.*);

// File: tb/tb_rx_eq_sequencer.sv
module tb_rx_eq_sequencer;
  localparam int COEF_W = 18;
  localparam int PW     = 4;
  localparam int MAXA   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, cmd_bypass = 1'b0;
  logic [PW-1:0] cmd_preset = '0, phy_lp_preset;
  logic [1:0] phy_eq_ctrl;
  logic phy_eq_done = 1'b0, phy_adapt_done = 1'b0, phy_preset_sel = 1'b0;
  logic [COEF_W-1:0] phy_new_coef = '0, res_coef;
  logic res_valid, res_preset_sel, eq_failed;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rx_eq_sequencer #(.COEF_W(COEF_W), .PRESET_W(PW), .MAX_ATTEMPTS(MAXA)) dut (.*);

  typedef struct packed {
    logic              bypass;
    logic [PW-1:0]     preset;
    logic [2:0]        nfail;
    logic [COEF_W-1:0] word;
    logic              psel;
    logic [3:0]        lat;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'h3, 3'd0, 18'h2A5C3, 1'b0, 4'd2},
    '{1'b1, 4'h9, 3'd0, 18'h3FFF7, 1'b1, 4'd3},
    '{1'b0, 4'hA, 3'd1, 18'h12345, 1'b0, 4'd2},
    '{1'b1, 4'h5, 3'd3, 18'h0F0FB, 1'b1, 4'd4},
    '{1'b0, 4'hF, 3'd4, 18'h11111, 1'b0, 4'd2},
    '{1'b1, 4'h0, 3'd2, 18'h00000, 1'b0, 4'd5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    logic [1:0] code;
    logic [COEF_W-1:0] expw;
    code = v.bypass ? 2'b11 : 2'b10;
    expw = v.psel ? {{(COEF_W-PW){1'b0}}, v.word[PW-1:0]} : v.word;
    @(negedge clk);
    chk("R2 ready before command", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_bypass = v.bypass; cmd_preset = v.preset;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R1 request code", 32'(phy_eq_ctrl), 32'(code));
    chk("R3 preset presented", 32'(phy_lp_preset), 32'(v.preset));
    chk("R2 ready low while outstanding", 32'(cmd_ready), 0);
    chk("R9 fail cleared on accept", 32'(eq_failed), 0);
    for (int a = 1; a <= MAXA; a++) begin
      for (int w = 0; w < int'(v.lat); w++) begin
        if (a == 1 && w == 0) begin
          cmd_valid = 1'b1; cmd_bypass = ~v.bypass; cmd_preset = ~v.preset;
        end
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      if (a == 1) begin
        chk("R2 command ignored: code", 32'(phy_eq_ctrl), 32'(code));
        chk("R2 command ignored: preset", 32'(phy_lp_preset), 32'(v.preset));
      end
      phy_eq_done = 1'b1;
      phy_adapt_done = (a == int'(v.nfail) + 1);
      phy_preset_sel = v.psel;
      phy_new_coef = v.word;
      @(negedge clk);
      phy_eq_done = 1'b0; phy_adapt_done = 1'b0;
      phy_new_coef = ~v.word; phy_preset_sel = ~v.psel;
      chk("R4 idle after done", 32'(phy_eq_ctrl), 0);
      if (a == int'(v.nfail) + 1) begin
        chk("R5 result valid", 32'(res_valid), 1);
        chk("R5 select latched", 32'(res_preset_sel), 32'(v.psel));
        chk("R6 result word", 32'(res_coef), 32'(expw));
        @(negedge clk);
        chk("R5 single pulse", 32'(res_valid), 0);
        chk("R5 word held", 32'(res_coef), 32'(expw));
        break;
      end else if (a == MAXA) begin
        chk("R8 fail flag", 32'(eq_failed), 1);
        chk("R8 ready after exhaust", 32'(cmd_ready), 1);
        chk("R5 no result on exhaust", 32'(res_valid), 0);
        repeat (3) @(negedge clk);
        chk("R8 stays idle", 32'(phy_eq_ctrl), 0);
        chk("R9 fail sticky", 32'(eq_failed), 1);
      end else begin
        chk("R7 ready low in gap", 32'(cmd_ready), 0);
        chk("R7 no result on failure", 32'(res_valid), 0);
        @(negedge clk);
        chk("R7 reissued code", 32'(phy_eq_ctrl), 32'(code));
        chk("R7 reissued preset", 32'(phy_lp_preset), 32'(v.preset));
      end
    end
  endtask

  initial begin
    repeat (500000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [COEF_W-1:0] held;
    repeat (3) @(negedge clk);
    chk("R11 reset ctrl", 32'(phy_eq_ctrl), 0);
    chk("R11 reset ready", 32'(cmd_ready), 1);
    chk("R11 reset valid", 32'(res_valid), 0);
    chk("R11 reset fail", 32'(eq_failed), 0);
    chk("R11 reset word", 32'(res_coef), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: stray done while idle (fail flag currently clear after last vector)
    held = res_coef;
    @(negedge clk);
    phy_eq_done = 1'b1; phy_adapt_done = 1'b1; phy_preset_sel = 1'b0;
    phy_new_coef = 18'h3ABCD;
    @(negedge clk);
    phy_eq_done = 1'b0; phy_adapt_done = 1'b0;
    chk("R10 no result from idle done", 32'(res_valid), 0);
    chk("R10 word unchanged", 32'(res_coef), 32'(held));
    chk("R10 stays idle", 32'(phy_eq_ctrl), 0);
    chk("R10 still ready", 32'(cmd_ready), 1);

    // R9: exhaust, then a stray done in idle, then clear on next command
    run_vec('{1'b0, 4'h6, 3'd4, 18'h00001, 1'b0, 4'd2});
    phy_eq_done = 1'b1; phy_adapt_done = 1'b0;
    @(negedge clk);
    phy_eq_done = 1'b0;
    chk("R9 fail survives idle done", 32'(eq_failed), 1);
    chk("R10 idle done no request", 32'(phy_eq_ctrl), 0);
    run_vec('{1'b1, 4'hC, 3'd0, 18'h2FFFF, 1'b1, 4'd2});
    chk("R9 fail cleared after new command", 32'(eq_failed), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule